// File: doc/BRIEF.md
# Dual-Match Periodic Down Counter

This block is a single timer channel. It loads a programmable reload value and steps down by one on each selected tick. When a step would take the count to zero, it reloads and keeps going, so the period is `reload` ticks. Each tick comes from one of two strobes, chosen by a select input: a fixed 1 MHz reference strobe, or a strobe in the bus clock domain.

Two match registers are compared with the running count. A match value that is not below the reload value counts as a match at zero. Every event inverts a level-style interrupt output and raises a one-cycle pulse that a status register outside the block can collect. An event is one of three things: the count stepping onto a match, or the wrap at zero when the overflow interrupt is enabled, or the wrap at zero when a match sits at zero.

Software writes the count, the reload value and the match values through write strobes that share one data bus. The readable count shows the live value while the channel is enabled and the reload value while it is disabled.

Top module: `dmt_timer`

## Requirements
- R1: After reset, `count_rd` reads 0, `irq_level` is 0 and `irq_set` is 0. Reload, both match registers and the counter all reset to 0.
- R2: The counter steps down by one for each tick of the selected source. `clk_sel`=1 selects `ref_tick` and `clk_sel`=0 selects `bus_tick`. A strobe on the unselected source has no effect. A tick strobe moves the count two clock edges after it is sampled.
- R3: A tick that arrives while the count is 1 (or 0) loads the reload value instead of stepping. This makes the count periodic with a period of `reload` ticks, and it never rests at 0 while running.
- R4: A tick that makes the count equal to a non-zero effective match value raises one event. Two distinct matches give two events per period. Two equal matches give a single event.
- R5: A match register whose value is greater than or equal to the reload value has an effective value of 0. It never fires during the count and it counts as a zero match at the wrap.
- R6: The wrap in R3 raises an event only if `ovf_irq_en` is 1 or at least one effective match value is 0.
- R7: Each event inverts `irq_level` and drives `irq_set` high for exactly one cycle, in the same cycle as the inversion. `irq_level` changes at no other time.
- R8: `count_rd` shows the live count while `enable` is 1 and the reload register while `enable` is 0.
- R9: A count write (`wr_count`) while enabled makes the counter continue from the written value. The write itself raises no event.
- R10: While reload is 0, ticks are ignored. Writing a non-zero reload while the old reload is 0 and the channel is enabled starts counting from the new value.
- R11: A rising edge on `enable` loads the counter with the reload value. While `enable` is 0, ticks raise no event and `irq_level` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe from the fixed 1 MHz reference |
| bus_tick | input | 1 | One-cycle strobe in the bus clock domain |
| clk_sel | input | 1 | Tick source: 1 = reference, 0 = bus |
| enable | input | 1 | Channel run enable |
| ovf_irq_en | input | 1 | Raise an event at the zero wrap |
| wr_count | input | 1 | Write strobe for the live count |
| wr_reload | input | 1 | Write strobe for the reload register |
| wr_match | input | N_MATCH (2) | Write strobes, one per match register |
| wr_data | input | CNT_W (32) | Write data shared by all strobes |
| count_rd | output | CNT_W (32) | Live count when enabled, reload when disabled |
| irq_level | output | 1 | Interrupt level, inverted on each event |
| irq_set | output | 1 | One-cycle pulse on each event |

## Verification
Several properties are checked by assertions on every clock:
- A single step per tick and the reload at wrap.
- Loading on an enable edge.
- A frozen count while disabled.
- The tight coupling between `irq_set` and each inversion of `irq_level`.

Other behaviours need the bench's scenarios, because they depend on how the programmed values relate to each other:
- Which counts fire for a given pair of matches.
- Treating an oversized match as zero.
- The conditional zero event.
- A single event for coincident matches.
- The count seen through the read mux.
- Restarting from a zero reload.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

   typedef enum logic {
      TICK_FROM_BUS = 1'b0,
      TICK_FROM_REF = 1'b1
   } tick_src_e;

   typedef struct packed {
      logic match_hit;
      logic zero_hit;
   } evt_cause_t;

endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick_i,
   input  logic bus_tick_i,
   input  logic sel_i,
   output logic tick_o
);
   import dmt_pkg::*;

   logic ref_strobe;
   logic tick_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_cfg
         $error("dmt_tick_sel: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign ref_strobe = ref_tick_i;
      end else begin : g_sync
         logic [SYNC_STAGES:0] shreg;
         always_ff @(posedge clk) begin
            if (!rst_n) shreg <= '0;
            else        shreg <= {shreg[SYNC_STAGES-1:0], ref_tick_i};
         end
         assign ref_strobe = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= (tick_src_e'(sel_i) == TICK_FROM_REF) ? ref_strobe : bus_tick_i;
   end

   assign tick_o = tick_q;

   // R2: a selected bus strobe always yields a tick one edge later
   assert_bus_tick_passes_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_i && bus_tick_i) |=> tick_o);

endmodule

// File: rtl/dmt_match_bank.sv
module dmt_match_bank #(
   parameter int CNT_W   = 32,
   parameter int N_MATCH = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [N_MATCH-1:0]              wr_match_i,
   input  logic [CNT_W-1:0]                wr_data_i,
   input  logic [CNT_W-1:0]                reload_i,
   output logic [N_MATCH-1:0][CNT_W-1:0]   eff_o
);
   generate
      if (N_MATCH < 1) begin : g_bad_cfg
         $error("dmt_match_bank: N_MATCH must be at least 1");
      end
      for (genvar i = 0; i < N_MATCH; i++) begin : g_slot
         logic [CNT_W-1:0] value_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             value_q <= '0;
            else if (wr_match_i[i]) value_q <= wr_data_i;
         end
         // R5: a value at or above reload behaves as a match at zero
         assign eff_o[i] = (value_q < reload_i) ? value_q : '0;
      end
   endgenerate

endmodule

// File: rtl/dmt_down_counter.sv
module dmt_down_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             wr_count_i,
   input  logic             wr_reload_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             dec_o,
   output logic [CNT_W-1:0] dec_val_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] reload_q;
   logic             en_q;
   logic             en_rise;
   logic             reload_live;
   logic             restart;

   assign en_rise     = en_i & ~en_q;
   assign reload_live = (reload_q != '0);
   assign restart     = wr_reload_i & ~reload_live & (wr_data_i != '0);

   always_comb begin
      cnt_d  = cnt_q;
      dec_o  = 1'b0;
      wrap_o = 1'b0;
      if (en_rise) begin
         cnt_d = reload_q;
      end else if (en_i && wr_count_i) begin
         cnt_d = wr_data_i;
      end else if (en_i && restart) begin
         cnt_d = wr_data_i;
      end else if (en_i && tick_i && reload_live) begin
         if (cnt_q <= CNT_W'(1)) begin
            cnt_d  = reload_q;
            wrap_o = 1'b1;
         end else begin
            cnt_d  = cnt_q - 1'b1;
            dec_o  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
         en_q     <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         en_q  <= en_i;
         if (wr_reload_i) reload_q <= wr_data_i;
      end
   end

   assign cnt_o     = cnt_q;
   assign reload_o  = reload_q;
   assign dec_val_o = cnt_q - 1'b1;

   // R2: one plain step per tick
   assert_single_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && en_q && tick_i && !wr_count_i && !wr_reload_i && reload_q != '0 && cnt_q > CNT_W'(1))
      |=> cnt_q == $past(cnt_q) - 1'b1);

   // R3: reload at the bottom of the count
   assert_wrap_reloads_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && en_q && tick_i && !wr_count_i && !wr_reload_i && reload_q != '0 && cnt_q <= CNT_W'(1))
      |=> cnt_q == $past(reload_q));

   // R11: enable edge loads reload
   assert_enable_loads_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !en_q) |=> cnt_q == $past(reload_q));

   // R11: disabled count is frozen
   assert_frozen_when_off_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/dmt_event_unit.sv
module dmt_event_unit #(
   parameter int CNT_W   = 32,
   parameter int N_MATCH = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dec_i,
   input  logic [CNT_W-1:0]              dec_val_i,
   input  logic                          wrap_i,
   input  logic                          ovf_ie_i,
   input  logic [N_MATCH-1:0][CNT_W-1:0] eff_i,
   output logic                          irq_level_o,
   output logic                          irq_set_o
);
   import dmt_pkg::*;

   logic [N_MATCH-1:0] hit_vec;
   logic [N_MATCH-1:0] zero_vec;
   evt_cause_t         cause;
   logic               irq_q, set_q;

   generate
      for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
         assign zero_vec[i] = (eff_i[i] == '0);
         assign hit_vec[i]  = dec_i & ~zero_vec[i] & (dec_val_i == eff_i[i]);
      end
   endgenerate

   assign cause.match_hit = |hit_vec;
   assign cause.zero_hit  = wrap_i & (ovf_ie_i | (|zero_vec));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         set_q <= 1'b0;
      end else begin
         set_q <= |cause;
         irq_q <= irq_q ^ (|cause);
      end
   end

   assign irq_level_o = irq_q;
   assign irq_set_o   = set_q;

   // R7: every status pulse comes with an inversion
   assert_set_flips_level_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      set_q |-> (irq_q != $past(irq_q)));

   // R7: the level only moves with a status pulse
   assert_level_needs_set_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q != $past(irq_q)) |-> set_q);

   // R11: no count movement, no event
   assert_no_spurious_event_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_i && !wrap_i) |=> !set_q);

endmodule

// File: rtl/dmt_timer.sv
module dmt_timer #(
   parameter int CNT_W       = 32,
   parameter int N_MATCH     = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   input  logic               bus_tick,
   input  logic               clk_sel,
   input  logic               enable,
   input  logic               ovf_irq_en,
   input  logic               wr_count,
   input  logic               wr_reload,
   input  logic [N_MATCH-1:0] wr_match,
   input  logic [CNT_W-1:0]   wr_data,
   output logic [CNT_W-1:0]   count_rd,
   output logic               irq_level,
   output logic               irq_set
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("dmt_timer: CNT_W must lie in 2..64");
      end
   endgenerate

   logic                          tick;
   logic [CNT_W-1:0]              cnt, reload, dec_val;
   logic                          dec, wrap;
   logic [N_MATCH-1:0][CNT_W-1:0] eff;

   dmt_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .bus_tick_i(bus_tick),
      .sel_i(clk_sel), .tick_o(tick));

   dmt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(enable), .tick_i(tick),
      .wr_count_i(wr_count), .wr_reload_i(wr_reload), .wr_data_i(wr_data),
      .cnt_o(cnt), .reload_o(reload), .dec_o(dec), .dec_val_o(dec_val), .wrap_o(wrap));

   dmt_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
      .clk(clk), .rst_n(rst_n), .wr_match_i(wr_match), .wr_data_i(wr_data),
      .reload_i(reload), .eff_o(eff));

   dmt_event_unit #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_evt (
      .clk(clk), .rst_n(rst_n), .dec_i(dec), .dec_val_i(dec_val), .wrap_i(wrap),
      .ovf_ie_i(ovf_irq_en), .eff_i(eff), .irq_level_o(irq_level), .irq_set_o(irq_set));

   // R8: read mux
   assign count_rd = enable ? cnt : reload;

endmodule

// File: tb/dmt_timer_tb_top.sv
module dmt_timer_tb_top;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_tick = 0, bus_tick = 0, clk_sel = 1, enable = 0, ovf_irq_en = 0;
   logic wr_count = 0, wr_reload = 0;
   logic [1:0] wr_match = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count_rd;
   logic irq_level, irq_set;

   int checks = 0;
   int fails = 0;
   logic exp_irq = 1'b0;

   always #10 clk = ~clk;

   dmt_timer dut_i (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_tick(bus_tick),
      .clk_sel(clk_sel), .enable(enable), .ovf_irq_en(ovf_irq_en),
      .wr_count(wr_count), .wr_reload(wr_reload), .wr_match(wr_match),
      .wr_data(wr_data), .count_rd(count_rd), .irq_level(irq_level), .irq_set(irq_set));

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input bit use_ref);
      @(negedge clk);
      if (use_ref) ref_tick = 1'b1; else bus_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0; bus_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr(input int kind, input logic [W-1:0] d);
      @(negedge clk);
      wr_data = d;
      case (kind)
         0: wr_count = 1'b1;
         1: wr_reload = 1'b1;
         2: wr_match = 2'b01;
         default: wr_match = 2'b10;
      endcase
      @(negedge clk);
      wr_count = 0; wr_reload = 0; wr_match = '0;
   endtask

   task automatic set_en(input logic v);
      @(negedge clk);
      enable = v;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; enable = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_irq = 1'b0;
      @(negedge clk);
   endtask

   // runs n ticks, returns the number of events seen
   task automatic run_ticks(input int n, input bit use_ref, output int events, output logic last_set);
      events = 0;
      last_set = 1'b0;
      for (int i = 0; i < n; i++) begin
         tick(use_ref);
         last_set = irq_set;
         if (irq_set) begin
            events++;
            exp_irq = ~exp_irq;
         end
      end
   endtask

   task automatic t_reset_state();
      chk("R1", "count_rd after reset", count_rd, 0);
      chk("R1", "irq_level after reset", irq_level, 0);
      chk("R1", "irq_set after reset", irq_set, 0);
   endtask

   task automatic t_basic_matches();
      clk_sel = 1; ovf_irq_en = 1;
      wr(1, 10); wr(2, 7); wr(3, 4);
      chk("R8", "count_rd disabled shows reload", count_rd, 10);
      set_en(1);
      chk("R11", "enable loads reload", count_rd, 10);
      tick(1); tick(1);
      chk("R2", "two ref ticks", count_rd, 8);
      chk("R4", "no event above match", irq_set, 0);
      tick(1);
      exp_irq = ~exp_irq;
      chk("R4", "count at first match", count_rd, 7);
      chk("R4", "event at larger match", irq_set, 1);
      chk("R7", "level inverted", irq_level, exp_irq);
      @(negedge clk);
      chk("R7", "set pulse lasts one cycle", irq_set, 0);
      tick(0);
      chk("R2", "bus tick ignored while ref selected", count_rd, 7);
      tick(1); tick(1); tick(1);
      exp_irq = ~exp_irq;
      chk("R4", "event at smaller match", irq_set, 1);
      chk("R7", "level inverted again", irq_level, exp_irq);
      tick(1); tick(1); tick(1);
      chk("R3", "count at one before wrap", count_rd, 1);
      tick(1);
      exp_irq = ~exp_irq;
      chk("R3", "wrap reloads", count_rd, 10);
      chk("R6", "zero event with overflow enabled", irq_set, 1);
      chk("R7", "level after zero event", irq_level, exp_irq);
   endtask

   task automatic t_clock_select();
      @(negedge clk); clk_sel = 0;
      tick(1);
      chk("R2", "ref tick ignored while bus selected", count_rd, 10);
      tick(0);
      chk("R2", "bus tick steps", count_rd, 9);
   endtask

   task automatic t_oversize_match();
      int ev; logic ls;
      set_en(0);
      ovf_irq_en = 0;
      wr(2, 10); wr(3, 20);
      set_en(1);
      run_ticks(9, 0, ev, ls);
      chk("R5", "oversize matches never fire mid count", ev, 0);
      chk("R3", "count reached one", count_rd, 1);
      run_ticks(1, 0, ev, ls);
      chk("R5", "oversize match acts as zero at wrap", ev, 1);
      chk("R7", "level tracks events", irq_level, exp_irq);
   endtask

   task automatic t_zero_gated();
      int ev; logic ls;
      set_en(0);
      wr(2, 6); wr(3, 3);
      set_en(1);
      run_ticks(10, 0, ev, ls);
      chk("R6", "two match events, no zero event", ev, 2);
      chk("R6", "wrap tick raised nothing", ls, 0);
      chk("R3", "period ends at reload", count_rd, 10);
      chk("R7", "level after period", irq_level, exp_irq);
   endtask

   task automatic t_coincident();
      int ev; logic ls;
      set_en(0);
      wr(2, 5); wr(3, 5);
      set_en(1);
      run_ticks(10, 0, ev, ls);
      chk("R4", "equal matches give one event", ev, 1);
   endtask

   task automatic t_disable();
      int ev; logic ls;
      logic lvl;
      tick(0); tick(0);
      chk("R2", "running before disable", count_rd, 8);
      set_en(0);
      chk("R8", "disabled read shows reload", count_rd, 10);
      lvl = irq_level;
      ovf_irq_en = 1;
      run_ticks(12, 0, ev, ls);
      chk("R11", "no events while disabled", ev, 0);
      chk("R11", "level holds while disabled", irq_level, lvl);
      set_en(1);
      chk("R11", "re-enable reloads", count_rd, 10);
      ovf_irq_en = 0;
   endtask

   task automatic t_count_write();
      wr(0, 5);
      chk("R9", "count write takes effect", count_rd, 5);
      chk("R9", "count write raises no event", irq_set, 0);
      tick(0);
      chk("R9", "continues from written value", count_rd, 4);
   endtask

   task automatic t_reload_start();
      do_reset();
      t_reset_state();
      clk_sel = 1; ovf_irq_en = 1;
      set_en(1);
      chk("R10", "zero reload reads zero", count_rd, 0);
      tick(1);
      chk("R10", "tick ignored with zero reload", count_rd, 0);
      chk("R10", "no event with zero reload", irq_set, 0);
      wr(1, 6);
      chk("R10", "reload write starts count", count_rd, 6);
      tick(1);
      chk("R10", "counting after start", count_rd, 5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_basic_matches();
      t_clock_select();
      t_oversize_match();
      t_zero_gated();
      t_coincident();
      t_disable();
      t_count_write();
      t_reload_start();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule